// File: doc/BRIEF.md
# Paged Effective Address Generator

This block forms the operand address for the memory-reference and jump instructions of a small 8-bit processor. The processor has four 16-bit pointers, and slot 0 of them is the program counter. All address arithmetic stays inside the 4 KB page of the base pointer. The upper four address bits pass through unchanged, and only the low twelve bits take part in the sum and wrap around.

The sequencer presents a request with four items: the low opcode bits, the 8-bit displacement byte, the extension register and the packed pointer set. One clock later the block returns the following registered results:
- the effective address;
- an immediate-mode flag;
- a pointer writeback strobe, with its pointer index and new value, for the auto-indexed modes;
- the page-wrapped increment of the program counter, used for the next fetch.

A displacement byte of 0x80 is not used as a displacement. The extension register takes its place.

Top module: `eag_core`

## Requirements
- R1: After reset, and until the first request, `vld_o`, `ptr_we_o` and `imm_o` are low and `ea_o` is 0x0000.
- R2: Every displacement sum keeps bits 15:12 of the base pointer and sets bits 11:0 to (base[11:0] + displacement) modulo 4096. The 8-bit displacement is sign-extended before the addition.
- R3: When `disp_i` is 0x80, the value of `ext_i` is used as the displacement. It is zero-extended, so it never counts as negative.
- R4: With `jmp_i` low and `op_i` = 0, the address is program counter (pointer 0) plus displacement.
- R5: With `jmp_i` low and `op_i` in 1..3, the address is pointer `op_i` plus displacement, and no writeback occurs.
- R6: With `jmp_i` low and `op_i` = 4, the address is the program counter itself and `imm_o` is high. No writeback occurs.
- R7: With `jmp_i` low, `op_i` in 5..7 and a negative displacement, the address is pointer `op_i`-4 plus displacement. `ptr_we_o` is high, `ptr_sel_o` is `op_i`-4, and `ptr_new_o` equals the address.
- R8: With `jmp_i` low, `op_i` in 5..7 and a non-negative displacement, the address is the unmodified pointer `op_i`-4. `ptr_we_o` is high and `ptr_new_o` is the pointer plus displacement.
- R9: With `jmp_i` high, `op_i[1:0]` selects the base pointer (0 is the program counter). The address is base plus displacement, and both `ptr_we_o` and `imm_o` are low.
- R10: `pc_inc_o` is pointer 0 plus one with the page wrap.
- R11: The results appear on the first clock edge after a cycle with `req_i` high, and `vld_o` is high for that cycle only. If no request was made the cycle before, `vld_o` and `ptr_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe; the inputs are sampled in this cycle |
| jmp_i | input | 1 | Jump form (base chosen by op_i[1:0]) |
| op_i | input | 3 | Low opcode bits, selecting the addressing mode |
| disp_i | input | 8 | Signed displacement byte |
| ext_i | input | 8 | Extension register, substituted for the displacement 0x80 |
| ptr_i | input | 64 | Pointers 0..3 packed, with pointer 0 (the PC) in bits 15:0 |
| vld_o | output | 1 | Results valid |
| ea_o | output | 16 | Effective address |
| imm_o | output | 1 | Immediate mode |
| ptr_we_o | output | 1 | Pointer writeback strobe |
| ptr_sel_o | output | 2 | Pointer index to write back |
| ptr_new_o | output | 16 | New pointer value |
| pc_inc_o | output | 16 | Program counter plus one, page-wrapped |

## Verification
The assertions run on every cycle and check these rules:
- the page number of every result equals that of its base pointer;
- writeback occurs only for auto-indexed requests;
- immediate mode returns the program counter;
- the valid and writeback strobes never appear without a request the cycle before.

The directed scenarios show the low-twelve-bit wrap values in both directions, the substitution of the extension register, and the choice between pre- and post-adjusted addresses in auto-indexing. They also show that the jump form chooses its base from the two low bits.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int ADDR_W  = 16;
  localparam int PAGE_W  = 12;
  localparam int DISP_W  = 8;
  localparam int NUM_PTR = 4;
  localparam int SEL_W   = $clog2(NUM_PTR);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [PAGE_W-1:0] ofs_t;
  typedef logic [SEL_W-1:0]  sel_t;

  typedef struct packed {
    sel_t sel;
    logic pre_sum;
    logic imm;
    logic wb;
  } dec_t;
endpackage

// File: rtl/eag_disp_sel.sv
module eag_disp_sel
  import eag_pkg::*;
#(
  parameter bit E_SIGNED = 1'b0
) (
  input  logic [DISP_W-1:0] disp_i,
  input  logic [DISP_W-1:0] ext_i,
  output ofs_t              disp_o,
  output logic              neg_o
);
  localparam logic [DISP_W-1:0] SUBST_CODE = {1'b1, {(DISP_W-1){1'b0}}};

  logic use_ext;
  logic ext_msb;

  assign use_ext = (disp_i == SUBST_CODE);

  generate
    if (E_SIGNED) begin : g_ext_sx
      assign ext_msb = ext_i[DISP_W-1];
    end else begin : g_ext_zx
      assign ext_msb = 1'b0;
    end
  endgenerate

  always_comb begin
    if (use_ext) begin
      disp_o = {{(PAGE_W-DISP_W){ext_msb}}, ext_i};
      neg_o  = ext_msb;
    end else begin
      disp_o = {{(PAGE_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
      neg_o  = disp_i[DISP_W-1];
    end
  end
endmodule

// File: rtl/eag_page_add.sv
module eag_page_add
  import eag_pkg::*;
(
  input  addr_t base_i,
  input  ofs_t  ofs_i,
  output addr_t sum_o
);
  ofs_t low_sum;

  assign low_sum = base_i[PAGE_W-1:0] + ofs_i;
  assign sum_o   = {base_i[ADDR_W-1:PAGE_W], low_sum};
endmodule

// File: rtl/eag_mode_dec.sv
module eag_mode_dec
  import eag_pkg::*;
(
  input  logic       jmp_i,
  input  logic [2:0] op_i,
  input  logic       neg_i,
  output dec_t       dec_o
);
  always_comb begin
    dec_o.sel     = op_i[SEL_W-1:0];
    dec_o.pre_sum = 1'b1;
    dec_o.imm     = 1'b0;
    dec_o.wb      = 1'b0;
    if (!jmp_i && op_i[2]) begin
      if (op_i[1:0] == 2'd0) begin
        dec_o.sel     = '0;
        dec_o.pre_sum = 1'b0;
        dec_o.imm     = 1'b1;
      end else begin
        dec_o.wb      = 1'b1;
        dec_o.pre_sum = neg_i;
      end
    end
  end
endmodule

// File: rtl/eag_core.sv
module eag_core
  import eag_pkg::*;
#(
  parameter bit E_SIGNED = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_i,
  input  logic                      jmp_i,
  input  logic [2:0]                op_i,
  input  logic [DISP_W-1:0]         disp_i,
  input  logic [DISP_W-1:0]         ext_i,
  input  logic [NUM_PTR*ADDR_W-1:0] ptr_i,
  output logic                      vld_o,
  output logic [ADDR_W-1:0]         ea_o,
  output logic                      imm_o,
  output logic                      ptr_we_o,
  output logic [SEL_W-1:0]          ptr_sel_o,
  output logic [ADDR_W-1:0]         ptr_new_o,
  output logic [ADDR_W-1:0]         pc_inc_o
);
  localparam ofs_t ONE = ofs_t'(1);

  logic  rst_s1, rst_sn;
  ofs_t  disp;
  logic  neg;
  dec_t  dec;
  addr_t base, pc, sum, pc_nx, ea_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  eag_disp_sel #(.E_SIGNED(E_SIGNED)) u_disp (
    .disp_i(disp_i), .ext_i(ext_i), .disp_o(disp), .neg_o(neg)
  );

  eag_mode_dec u_dec (
    .jmp_i(jmp_i), .op_i(op_i), .neg_i(neg), .dec_o(dec)
  );

  assign pc   = ptr_i[ADDR_W-1:0];
  assign base = ptr_i[dec.sel*ADDR_W +: ADDR_W];

  eag_page_add u_sum (.base_i(base), .ofs_i(disp), .sum_o(sum));
  eag_page_add u_inc (.base_i(pc),   .ofs_i(ONE),  .sum_o(pc_nx));

  always_comb begin
    if (dec.imm)          ea_nx = pc;
    else if (dec.pre_sum) ea_nx = sum;
    else                  ea_nx = base;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      vld_o     <= 1'b0;
      ptr_we_o  <= 1'b0;
      ea_o      <= '0;
      imm_o     <= 1'b0;
      ptr_sel_o <= '0;
      ptr_new_o <= '0;
      pc_inc_o  <= '0;
    end else begin
      vld_o    <= req_i;
      ptr_we_o <= req_i & dec.wb;
      if (req_i) begin
        ea_o      <= ea_nx;
        imm_o     <= dec.imm;
        ptr_sel_o <= dec.sel;
        ptr_new_o <= sum;
        pc_inc_o  <= pc_nx;
      end
    end
  end

  // R5 R6 R9
  wb_only_auto_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (req_i && (jmp_i || !op_i[2] || op_i[1:0] == 2'd0)) |=> !ptr_we_o);

  // R6
  imm_is_pc_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (req_i && !jmp_i && op_i == 3'd4) |=> (imm_o && ea_o == $past(pc)));

  // R2
  wb_same_page_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    ptr_we_o |-> (ptr_new_o[ADDR_W-1:PAGE_W] == ea_o[ADDR_W-1:PAGE_W]));

  // R10
  pc_inc_page_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    req_i |=> (pc_inc_o[ADDR_W-1:PAGE_W] == $past(pc[ADDR_W-1:PAGE_W])));

  // R11
  no_req_idle_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !req_i |=> (!vld_o && !ptr_we_o));
endmodule

// File: tb/eag_core_bench.sv
module eag_core_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_i, jmp_i;
  logic [2:0]  op_i;
  logic [7:0]  disp_i, ext_i;
  logic [63:0] ptr_i;
  logic        vld_o, imm_o, ptr_we_o;
  logic [15:0] ea_o, ptr_new_o, pc_inc_o;
  logic [1:0]  ptr_sel_o;
  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  eag_core u_eag_core (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .jmp_i(jmp_i), .op_i(op_i),
    .disp_i(disp_i), .ext_i(ext_i), .ptr_i(ptr_i), .vld_o(vld_o),
    .ea_o(ea_o), .imm_o(imm_o), .ptr_we_o(ptr_we_o), .ptr_sel_o(ptr_sel_o),
    .ptr_new_o(ptr_new_o), .pc_inc_o(pc_inc_o)
  );

  function automatic logic [15:0] wrap(input logic [15:0] b, input int d);
    logic [11:0] lo;
    lo = 12'((int'(b[11:0]) + d + 8192) % 4096);
    return {b[15:12], lo};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic j, input logic [2:0] op, input logic [7:0] d,
                       input logic [7:0] e, input logic [63:0] p);
    @(negedge clk);
    req_i = 1'b1; jmp_i = j; op_i = op; disp_i = d; ext_i = e; ptr_i = p;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 vld", 32'(vld_o), 0);
    chk("R1 we", 32'(ptr_we_o), 0);
    chk("R1 imm", 32'(imm_o), 0);
    chk("R1 ea", 32'(ea_o), 0);
  endtask

  task automatic t_pcrel;
    issue(0, 3'd0, 8'h05, 8'h00, {48'h0, 16'h1FFE});
    chk("R4 R2 pc-rel wrap ea", 32'(ea_o), 32'(wrap(16'h1FFE, 5)));
    chk("R11 vld", 32'(vld_o), 1);
    chk("R5 R4 no wb", 32'(ptr_we_o), 0);
    chk("R10 pc_inc", 32'(pc_inc_o), 32'h1FFF);
  endtask

  task automatic t_indexed;
    issue(0, 3'd2, 8'hFD, 8'h00, {16'h0, 16'h3001, 16'h0, 16'h0100});
    chk("R5 R2 idx p2 neg wrap", 32'(ea_o), 32'h3FFE);
    chk("R5 no wb", 32'(ptr_we_o), 0);
    chk("R5 imm low", 32'(imm_o), 0);
  endtask

  task automatic t_subst;
    issue(0, 3'd1, 8'h80, 8'hF0, {16'h0, 16'h0, 16'h4020, 16'h0});
    chk("R3 E substituted", 32'(ea_o), 32'h4110);
  endtask

  task automatic t_imm;
    issue(0, 3'd4, 8'h33, 8'h00, {16'h7777, 16'h6666, 16'h5555, 16'h0FFF});
    chk("R6 ea is pc", 32'(ea_o), 32'h0FFF);
    chk("R6 imm", 32'(imm_o), 1);
    chk("R6 no wb", 32'(ptr_we_o), 0);
    chk("R10 pc_inc wrap", 32'(pc_inc_o), 32'h0000);
  endtask

  task automatic t_auto_neg;
    issue(0, 3'd7, 8'hFF, 8'h00, {16'h5000, 16'h0, 16'h0, 16'h0});
    chk("R7 ea pre-dec", 32'(ea_o), 32'h5FFF);
    chk("R7 we", 32'(ptr_we_o), 1);
    chk("R7 sel", 32'(ptr_sel_o), 3);
    chk("R7 new", 32'(ptr_new_o), 32'h5FFF);
  endtask

  task automatic t_auto_pos;
    issue(0, 3'd5, 8'h02, 8'h00, {16'h0, 16'h0, 16'h2FFF, 16'h0});
    chk("R8 ea unmodified", 32'(ea_o), 32'h2FFF);
    chk("R8 we", 32'(ptr_we_o), 1);
    chk("R8 sel", 32'(ptr_sel_o), 1);
    chk("R8 new post-inc wrap", 32'(ptr_new_o), 32'h2001);
    issue(0, 3'd6, 8'h80, 8'h90, {16'h0, 16'h8F80, 16'h0, 16'h0});
    chk("R3 R8 E non-negative ea", 32'(ea_o), 32'h8F80);
    chk("R3 R8 E new", 32'(ptr_new_o), 32'(wrap(16'h8F80, 144)));
  endtask

  task automatic t_jump;
    issue(1, 3'd6, 8'h10, 8'h00, {16'h0, 16'hA123, 16'h0, 16'h0200});
    chk("R9 jump base p2", 32'(ea_o), 32'hA133);
    chk("R9 no wb", 32'(ptr_we_o), 0);
    chk("R9 imm low", 32'(imm_o), 0);
    issue(1, 3'd4, 8'hF0, 8'h00, {16'h0, 16'h0, 16'h0, 16'h0005});
    chk("R9 jump base pc", 32'(ea_o), 32'h0FF5);
  endtask

  task automatic t_idle;
    @(negedge clk);
    chk("R11 vld pulse ends", 32'(vld_o), 0);
    chk("R11 we low idle", 32'(ptr_we_o), 0);
  endtask

  initial begin
    rst_n = 1'b0; req_i = 1'b0; jmp_i = 1'b0; op_i = '0;
    disp_i = '0; ext_i = '0; ptr_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_pcrel();
    t_indexed();
    t_subst();
    t_imm();
    t_auto_neg();
    t_auto_pos();
    t_jump();
    t_idle();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule